// File: doc/BRIEF.md
# Cascadable Up/Down Counter Stage

This block is one synchronous binary counter stage, four bits wide by default. It counts up or down, loads a preset value on a clock edge, and holds its value. Every bit of the count changes on the same rising clock edge, so the outputs never ripple. An active-low load input overrides everything except reset. Counting needs both active-low enables at LOW. One of those enables, the trickle enable, also gates an active-low terminal-count output.

The terminal-count output goes LOW at the stage's end value: all ones when counting up, all zeros when counting down. The trickle enable must also be LOW. To build a wider synchronous counter, connect the terminal-count output of each stage to the trickle enable of the next stage. The parallel enable and the clock go to every stage, so no extra gating is needed. A synchronous reset to zero is provided for simulation and test.

The block has no data stream. Every pin is a plain level-sensitive control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `updown_cascade_ctr`

## Requirements
- R1: When `rst` is HIGH at a rising edge, the count becomes zero. This holds whatever the levels of `load_n` and both enables.
- R2: When `rst` is LOW and `load_n` is LOW at a rising edge, the count takes the value of `load_val`. The levels of `en_par_n` and `en_trk_n` do not matter.
- R3: When `rst` and `load_n` are inactive, `en_par_n` and `en_trk_n` are both LOW and `up_sel` is HIGH, the count increases by one at each rising edge. It wraps from all ones to zero.
- R4: Under the same conditions with `up_sel` LOW, the count decreases by one at each rising edge. It wraps from zero to all ones.
- R5: When `load_n` is HIGH and either enable is HIGH, the count keeps its value across the rising edge.
- R6: `term_n` is combinational and idles HIGH. It is LOW only when `en_trk_n` is LOW and one of these holds: the count is all ones with `up_sel` HIGH, or the count is zero with `up_sel` LOW. `term_n` does not depend on `en_par_n`.
- R7: Two stages can be chained into one wider counter. Connect the low stage's `term_n` to the high stage's `en_trk_n`, and share `en_par_n`, `up_sel` and the clock between the stages. The pair then counts, loads, wraps and holds as one 8-bit counter. Its carry is the high stage's `term_n`.
- R8: While free-running upward, count bit k toggles once every 2^k clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset to zero, active HIGH, highest priority |
| load_n | input | 1 | Active-low synchronous load of `load_val` |
| en_par_n | input | 1 | Active-low parallel count enable |
| en_trk_n | input | 1 | Active-low trickle count enable; also gates `term_n` |
| up_sel | input | 1 | Direction: HIGH counts up, LOW counts down |
| load_val | input | W | Preset value |
| count | output | W | Current count |
| term_n | output | 1 | Active-low terminal count |

## Verification
The bench chains two stages into an 8-bit counter and compares them with a behavioural model on every clock. The stimulus covers several cases:
- A load applied while both enables are HIGH shows that load overrides the enables.
- Upward runs across 0xFF and downward runs across 0x00 separate a true 8-bit carry or borrow from a stage that wraps on its own.
- Holding with each enable HIGH in turn shows which enable stops counting. It also shows that the carry follows only the trickle enable.
- Asserting reset together with load proves the priority between the two.
- Long free runs in both directions exercise every nibble carry and the bit toggle rates.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
  import ctr_pkg::*;
(
  input  logic    rst,
  input  logic    load_n,
  input  logic    en_par_n,
  input  logic    en_trk_n,
  output ctr_op_e op
);
  always_comb begin
    if (rst)                        op = OP_CLEAR;
    else if (!load_n)               op = OP_LOAD;
    else if (!en_par_n && !en_trk_n) op = OP_STEP;
    else                            op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_next.sv
module ctr_next
  import ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  ctr_op_e      op,
  input  logic         up_sel,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] stepped;

  assign stepped = up_sel ? (cur + ONE) : (cur - ONE);

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = load_val;
      OP_STEP:  nxt = stepped;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/ctr_term.sv
module ctr_term #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         up_sel,
  input  logic         en_trk_n,
  output logic         term_n
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic at_end;

  assign at_end = up_sel ? (cur == TOP) : (cur == '0);
  assign term_n = ~(at_end & ~en_trk_n);
endmodule

// File: rtl/updown_cascade_ctr.sv
module updown_cascade_ctr
  import ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic         en_par_n,
  input  logic         en_trk_n,
  input  logic         up_sel,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         term_n
);
  ctr_op_e      op;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  ctr_op_decode u_dec (
    .rst      (rst),
    .load_n   (load_n),
    .en_par_n (en_par_n),
    .en_trk_n (en_trk_n),
    .op       (op)
  );

  ctr_next #(.W(W)) u_next (
    .op       (op),
    .up_sel   (up_sel),
    .cur      (cnt_q),
    .load_val (load_val),
    .nxt      (cnt_d)
  );

  ctr_term #(.W(W)) u_term (
    .cur      (cnt_q),
    .up_sel   (up_sel),
    .en_trk_n (en_trk_n),
    .term_n   (term_n)
  );

  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/updown_cascade_ctr_chk.sv
module updown_cascade_ctr_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         load_n,
  input logic         en_par_n,
  input logic         en_trk_n,
  input logic         up_sel,
  input logic [W-1:0] load_val,
  input logic [W-1:0] count,
  input logic         term_n
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> count == '0);

  // R2
  load_takes_value_chk: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> count == $past(load_val));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && !en_par_n && !en_trk_n && up_sel) |=> count == $past(count) + ONE);

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && !en_par_n && !en_trk_n && !up_sel) |=> count == $past(count) - ONE);

  // R5
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && (en_par_n || en_trk_n)) |=> $stable(count));

  // R6
  term_idle_chk: assert property (@(posedge clk) disable iff (rst)
    en_trk_n |-> term_n);

  // R6
  term_up_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_trk_n && up_sel && count == TOP) |-> !term_n);

  // R6
  term_down_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_trk_n && !up_sel && count == '0) |-> !term_n);
endmodule

bind updown_cascade_ctr updown_cascade_ctr_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load_n   (load_n),
  .en_par_n (en_par_n),
  .en_trk_n (en_trk_n),
  .up_sel   (up_sel),
  .load_val (load_val),
  .count    (count),
  .term_n   (term_n)
);

// File: tb/tb_updown_cascade_ctr.sv
module tb_updown_cascade_ctr;
  localparam int CLK_P = 10;
  localparam int W = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_n = 1'b1;
  logic       par_n = 1'b0;
  logic       trk_n = 1'b0;
  logic       up = 1'b1;
  logic [7:0] ld = 8'h00;

  logic [3:0] lo_cnt;
  logic [3:0] hi_cnt;
  logic       lo_term;
  logic       hi_term;

  int checks = 0;
  int fails  = 0;
  int exp_v  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  updown_cascade_ctr #(.W(W)) dut (
    .clk(clk), .rst(rst), .load_n(load_n), .en_par_n(par_n), .en_trk_n(trk_n),
    .up_sel(up), .load_val(ld[3:0]), .count(lo_cnt), .term_n(lo_term)
  );

  updown_cascade_ctr #(.W(W)) dut_hi (
    .clk(clk), .rst(rst), .load_n(load_n), .en_par_n(par_n), .en_trk_n(lo_term),
    .up_sel(up), .load_val(ld[7:4]), .count(hi_cnt), .term_n(hi_term)
  );

  // Behavioural reference of an 8-bit chained counter
  always @(posedge clk) begin
    if (rst)                      exp_v <= 0;
    else if (!load_n)             exp_v <= int'(ld);
    else if (!par_n && !trk_n)    exp_v <= up ? (exp_v + 1) % 256 : (exp_v + 255) % 256;
  end

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Compare every clock, away from the rising edge
  task automatic step(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int lo_e;
      int ch_term;
      int lo_t;
      @(negedge clk);
      lo_e    = exp_v % 16;
      ch_term = (!trk_n && ((up && exp_v == 255) || (!up && exp_v == 0))) ? 0 : 1;
      lo_t    = (!trk_n && ((up && lo_e == 15) || (!up && lo_e == 0))) ? 0 : 1;
      chk({tag, " count"}, int'({hi_cnt, lo_cnt}), exp_v);
      chk({tag, " chain_term"}, int'(hi_term), ch_term);
      chk({tag, " stage_term"}, int'(lo_term), lo_t);
    end
  endtask

  initial begin
    int q0_tog;
    logic q0_prev;
    // R1 reset state
    step(2, "R1 reset");
    rst = 1'b0;
    // R2 load with both enables HIGH
    par_n = 1'b1; trk_n = 1'b1; load_n = 1'b0; ld = 8'hF8;
    step(1, "R2 load");
    load_n = 1'b1;
    step(1, "R2 loaded");
    // R3 up with wrap through 0xFF, R7 carry between stages
    par_n = 1'b0; trk_n = 1'b0; up = 1'b1;
    step(12, "R3 R7 up wrap");
    // R5 hold with each enable HIGH
    par_n = 1'b1;
    step(4, "R5 hold par");
    par_n = 1'b0; trk_n = 1'b1;
    step(4, "R5 hold trk");
    // R4 down with wrap through 0x00
    trk_n = 1'b0; load_n = 1'b0; ld = 8'h03;
    step(1, "R2 load down");
    load_n = 1'b1; up = 1'b0;
    step(8, "R4 R7 down wrap");
    // R6 terminal count independent of the parallel enable
    load_n = 1'b0; ld = 8'hFF; up = 1'b1; par_n = 1'b1;
    step(1, "R6 load top");
    load_n = 1'b1;
    step(2, "R6 par high");
    chk("R6 term low at top", int'(hi_term), 0);
    par_n = 1'b0; trk_n = 1'b1;
    step(1, "R6 trk high");
    chk("R6 term idle", int'(lo_term), 1);
    // R1 reset beats load
    trk_n = 1'b0; rst = 1'b1; load_n = 1'b0; ld = 8'hAA;
    step(2, "R1 reset over load");
    rst = 1'b0; load_n = 1'b1;
    // R8 free run up: bit 0 toggles every cycle, compared over 16 cycles
    q0_tog = 0;
    q0_prev = lo_cnt[0];
    for (int i = 0; i < 16; i++) begin
      step(1, "R8 free up");
      if (lo_cnt[0] != q0_prev) q0_tog++;
      q0_prev = lo_cnt[0];
    end
    chk("R8 bit0 toggles", q0_tog, 16);
    step(300, "R7 R8 long up");
    up = 1'b0;
    step(300, "R4 R7 long down");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule